// File: doc/BRIEF.md
# Keyed LFSR Byte Scrambler

This block sits in a byte stream and XORs each byte with the low eight bits of a running 16-bit key. After every byte it handles on an enabled channel, the key moves one step through a CRC-style linear feedback shift register. The feedback polynomial is 0x1021. Because XOR undoes itself, the same block decrypts a stream when its key sequence is started from the same value.

The byte path is a plain valid/ready pass-through with no storage. Each byte carries an address and a channel number. A small register port holds the following:

- a control word, with one enable per channel, an enable for the address window, and a reload command;
- a write-only seed;
- a view of the live key;
- the two bounds of the window.

While the window is enabled, bytes whose address lies inside it pass through unchanged. They still advance the key, so the keystream stays tied to byte position.

Top module: `lfsr_stream_scrambler`

## Requirements
- R1: After reset, the control word, the live key and both window bounds all read 0.
- R2: A byte on an enabled channel, outside any active window, leaves as in_data XOR live_key[7:0], in the same cycle it is offered.
- R3: Each accepted byte (in_valid and out_ready high) on an enabled channel replaces the live key with (key<<1) XOR (key[15] ? 16'h1021 : 0), kept to 16 bits.
- R4: A byte on a disabled channel leaves unchanged and does not advance the key. Channel c is enabled by control bit c (bits 3:0).
- R5: When control bit 4 is set, a byte whose address satisfies start <= addr <= end leaves unchanged and still advances the key. Addresses just outside the bounds are scrambled.
- R6: When control bit 4 is clear, addresses inside the window bounds are scrambled normally.
- R7: Writing offset 0x04 stores bits 15:0 as the seed and loads the live key with that value on the next edge. Offset 0x04 reads 0.
- R8: Writing control (offset 0x00) with bit 7 set reloads the live key from the seed. This takes priority over a byte accepted in the same cycle. Bit 7 reads back 0.
- R9: A byte offered while out_ready is low is not accepted and does not advance the key.
- R10: Reads are combinational: 0x00 gives the channel enables in bits 3:0 and the window enable in bit 4; 0x08 gives the live key; 0x0C gives the window end; 0x10 gives the window start.
- R11: Scrambling a stream and then feeding its output back in from the same seed returns the original bytes.
- R12: out_valid follows in_valid and in_ready follows out_ready combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_addr | input | ADDR_W (32) | Byte address for window test |
| in_chan | input | CHAN_W (2) | Channel number |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | 8 | Output byte |

## Verification
The bench builds the block with its default parameters: a 32-bit address, four channels and the 0x1021 feedback. With these settings every channel enable bit can be toggled on its own. The window bounds can be placed at 0x100 and 0x1FF, so bytes at 0xFF, 0x100, 0x1FF and 0x200 probe both edges of the inclusive range. The seed 0xACE1 has bit 15 set, which makes the feedback term act from the very first step.

// File: rtl/lfsr_stream_scrambler.sv
module lfsr_stream_scrambler #(
  parameter int          ADDR_W = 32,
  parameter int          CHAN_N = 4,
  parameter int          CHAN_W = (CHAN_N > 1) ? $clog2(CHAN_N) : 1,
  parameter logic [15:0] POLY   = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CHAN_W-1:0] in_chan,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data
);
  localparam logic [4:0] OFS_CTRL = 5'h00;
  localparam logic [4:0] OFS_SEED = 5'h04;
  localparam logic [4:0] OFS_LIVE = 5'h08;
  localparam logic [4:0] OFS_END  = 5'h0C;
  localparam logic [4:0] OFS_BEG  = 5'h10;
  localparam int WIN_BIT    = 4;
  localparam int RELOAD_BIT = 7;

  logic [CHAN_N-1:0] chan_en;
  logic              win_en;
  logic [15:0]       seed_q, live_q, live_d, live_step;
  logic [ADDR_W-1:0] win_beg, win_end;
  logic              chan_on, in_win, scramble, fire, ld_seed, reload;

  assign chan_on   = (int'(in_chan) < CHAN_N) && chan_en[in_chan];
  assign in_win    = win_en && (in_addr >= win_beg) && (in_addr <= win_end);
  assign scramble  = chan_on && !in_win;
  assign fire      = in_valid && out_ready && chan_on;
  assign ld_seed   = reg_we && (reg_addr == OFS_SEED);
  assign reload    = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[RELOAD_BIT];
  assign live_step = {live_q[14:0], 1'b0} ^ (live_q[15] ? POLY : 16'h0000);

  assign out_valid = in_valid;
  assign in_ready  = out_ready;
  assign out_data  = in_data ^ (scramble ? live_q[7:0] : 8'h00);

  always_comb begin
    live_d = live_q;
    if (ld_seed)     live_d = reg_wdata[15:0];
    else if (reload) live_d = seed_q;
    else if (fire)   live_d = live_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en <= '0;
      win_en  <= 1'b0;
      seed_q  <= '0;
      live_q  <= '0;
      win_beg <= '0;
      win_end <= '0;
    end else begin
      live_q <= live_d;
      if (reg_we) begin
        case (reg_addr)
          OFS_CTRL: begin
            chan_en <= reg_wdata[CHAN_N-1:0];
            win_en  <= reg_wdata[WIN_BIT];
          end
          OFS_SEED: seed_q  <= reg_wdata[15:0];
          OFS_END:  win_end <= reg_wdata[ADDR_W-1:0];
          OFS_BEG:  win_beg <= reg_wdata[ADDR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CHAN_N-1:0] = chan_en;
        reg_rdata[WIN_BIT]    = win_en;
      end
      OFS_LIVE: reg_rdata[15:0]       = live_q;
      OFS_END:  reg_rdata[ADDR_W-1:0] = win_end;
      OFS_BEG:  reg_rdata[ADDR_W-1:0] = win_beg;
      default: ;
    endcase
  end

  AST_KEY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_ready && chan_on && !reg_we) |=>
      live_q == ({$past(live_q[14:0]), 1'b0} ^ ($past(live_q[15]) ? POLY : 16'h0000))); // R3
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && out_ready && chan_on) && !reg_we) |=> $stable(live_q)); // R9
  AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_seed |=> (live_q == $past(reg_wdata[15:0])) && (seed_q == live_q)); // R7
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> live_q == $past(seed_q)); // R8
  AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && chan_en == '0) |-> out_data == in_data); // R4
endmodule

// File: tb/lfsr_stream_scrambler_tb_top.sv
module lfsr_stream_scrambler_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_chan = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;

  int total = 0;
  int bad = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] cap_q[$];

  logic [3:0]  m_en = '0;
  logic        m_win = 1'b0;
  logic [31:0] m_beg = '0, m_end = '0;
  logic [15:0] m_seed = '0, m_live = '0;

  always #4 clk = ~clk;

  lfsr_stream_scrambler dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_addr(in_addr),
    .in_chan(in_chan), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  function automatic logic [15:0] step(input logic [15:0] k);
    return {k[14:0], 1'b0} ^ (k[15] ? 16'h1021 : 16'h0000);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk("R2 unexpected byte", {24'h0, out_data}, 32'hxxxxxxxx);
      else chk(tag_q.pop_front(), {24'h0, out_data}, {24'h0, exp_q.pop_front()});
      cap_q.push_back(out_data);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      5'h00: begin m_en = d[3:0]; m_win = d[4]; if (d[7]) m_live = m_seed; end
      5'h04: begin m_seed = d[15:0]; m_live = d[15:0]; end
      5'h0C: m_end = d;
      5'h10: m_beg = d;
      default: ;
    endcase
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  function automatic logic [7:0] model(input logic [7:0] d, input logic [31:0] a, input logic [1:0] c);
    logic on, inw;
    logic [7:0] r;
    on  = m_en[c];
    inw = m_win && a >= m_beg && a <= m_end;
    r   = (on && !inw) ? d ^ m_live[7:0] : d;
    if (on) m_live = step(m_live);
    return r;
  endfunction

  task automatic send(input logic [7:0] d, input logic [31:0] a, input logic [1:0] c, input string tag);
    @(posedge clk); #1;
    exp_q.push_back(model(d, a, c));
    tag_q.push_back(tag);
    in_valid = 1'b1; in_data = d; in_addr = a; in_chan = c;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] plain[6];
    logic [7:0] ct[$];
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(5'h00, 0, "R1 ctrl");
    rd(5'h08, 0, "R1 live");
    rd(5'h0C, 0, "R1 end");
    rd(5'h10, 0, "R1 beg");

    wr(5'h04, 32'hFFFF_ACE1);
    rd(5'h08, 32'h0000ACE1, "R7 live after seed write");
    rd(5'h04, 0, "R7 seed reads zero");

    wr(5'h00, 32'h1);
    rd(5'h00, 32'h1, "R10 ctrl readback");
    for (int i = 0; i < 5; i++) send(8'h30 + 8'(i * 7), 32'h40 + i, 2'd0, "R2 chan0 scramble");
    rd(5'h08, {16'h0, m_live}, "R3 key after five steps");
    send(8'h5A, 32'h44, 2'd1, "R4 disabled chan passes");
    send(8'hC3, 32'h45, 2'd3, "R4 disabled chan passes");
    rd(5'h08, {16'h0, m_live}, "R4 key not stepped");

    wr(5'h10, 32'h100);
    wr(5'h0C, 32'h1FF);
    rd(5'h10, 32'h100, "R10 beg readback");
    rd(5'h0C, 32'h1FF, "R10 end readback");
    wr(5'h00, 32'hF);
    send(8'h11, 32'h150, 2'd2, "R6 window off scrambles");
    send(8'h22, 32'h100, 2'd1, "R6 window off scrambles");
    wr(5'h00, 32'h1F);
    send(8'h33, 32'h100, 2'd0, "R5 start bound bypass");
    send(8'h44, 32'h1FF, 2'd3, "R5 end bound bypass");
    send(8'h55, 32'hFF, 2'd1, "R5 below start scrambles");
    send(8'h66, 32'h200, 2'd2, "R5 above end scrambles");
    rd(5'h08, {16'h0, m_live}, "R5 bypass still steps key");

    @(posedge clk); #1;
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h99; in_addr = 32'h300; in_chan = 2'd0;
    @(negedge clk);
    chk("R12 in_ready follows out_ready", {31'h0, in_ready}, 0);
    chk("R12 out_valid follows in_valid", {31'h0, out_valid}, 1);
    repeat (2) @(posedge clk);
    #1 in_valid = 1'b0; out_ready = 1'b1;
    rd(5'h08, {16'h0, m_live}, "R9 no step while stalled");

    wr(5'h00, 32'h9F);
    rd(5'h00, 32'h1F, "R8 reload bit reads zero");
    rd(5'h08, 32'h0000ACE1, "R8 live reloaded");
    send(8'h77, 32'h300, 2'd0, "R8 byte after reload");
    @(posedge clk); #1;
    exp_q.push_back(model(8'hE4, 32'h300, 2'd2));
    tag_q.push_back("R8 byte in reload cycle");
    m_live = m_seed;
    in_valid = 1'b1; in_data = 8'hE4; in_addr = 32'h300; in_chan = 2'd2;
    reg_we = 1'b1; reg_addr = 5'h00; reg_wdata = 32'h9F;
    @(posedge clk); #1;
    in_valid = 1'b0; reg_we = 1'b0;
    rd(5'h08, 32'h0000ACE1, "R8 reload beats step");

    wr(5'h04, 32'h0000_8001);
    cap_q.delete();
    for (int i = 0; i < 6; i++) begin
      plain[i] = 8'hA0 ^ 8'(i * 29);
      send(plain[i], 32'h400, 2'd1, "R2 round trip encrypt");
    end
    ct = cap_q;
    wr(5'h00, 32'h9F);
    cap_q.delete();
    for (int i = 0; i < 6; i++) send(ct[i], 32'h400, 2'd1, "R11 round trip decrypt");
    for (int i = 0; i < 6; i++) chk("R11 recovered plaintext", {24'h0, cap_q[i]}, {24'h0, plain[i]});

    repeat (2) @(posedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule